// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Flush Matching

This block is the small, fully associative translation cache that sits in front of a device-side IOMMU's page-table walker. Each line remembers one 4 KB page translation: a 7-bit address-space identifier and a 20-bit virtual page number as the tag, and a physical frame number with read, write and non-secure permission bits as the payload. A lookup presented on one cycle is answered on the next with hit or miss, plus the frame and permissions on a hit. After a miss, the walker installs the translation through a refill port.

Invalidation arrives as a single 32-bit command word. The word can optionally restrict the flush to one address space. It also chooses whether every address matches, or only a 4 MB section, or only a 16 KB group. Three configuration inputs control the rest: how many lines take part, whether lookups that hit may still be served while a miss waits for its refill, and whether replacement rotates round-robin once every active line is valid.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` is 0, `lk_ready` is 1, and any lookup misses.
- R2: A lookup accepted in cycle t (`lk_valid` and `lk_ready`) gives `rsp_valid`=1 in cycle t+1. On a match of both address-space ID and page number against a valid active line, it also gives `rsp_hit`=1 with that line's frame and permissions.
- R3: Flush word bits 1:0 select the address match. Code 0 matches every address, code 2 a 4 MB section, code 3 a 16 KB group, and code 1 matches nothing.
- R4: When flush word bit 31 is 1, only lines whose address-space ID equals bits 30:24 are flushed. When bit 31 is 0, the address-space ID is not compared.
- R5: A section flush compares page-number bits 19:10 (VA 31:22) with word bits 19:10. A group flush compares page-number bits 19:2 (VA 31:14) with word bits 19:2.
- R6: A flushed line is invalid from the cycle after the command. A lookup in the same cycle as the flush does not hit that line.
- R7: A lookup in the same cycle as a refill of the same tag misses. The installed entry hits from the next cycle on.
- R8: Refill writes the lowest-numbered invalid active line. When none is free, it writes the round-robin pointer's line if `cfg_round_robin`=1, or else line 0. The pointer advances and wraps at the active count only on such replacements.
- R9: Only lines below the active count (`cfg_active_lines`, where 0 or a value above the line count means all lines) can hit or be refilled.
- R10: After a miss with `cfg_hit_under_miss`=0, `lk_ready` stays 0 until a refill is presented. With the bit set, `lk_ready` stays 1 and lookups keep being answered.
- R11: A miss response carries a frame number of 0 and all permission bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active_lines | input | 6 | Number of participating lines (0 = all) |
| cfg_hit_under_miss | input | 1 | Keep serving lookups while a miss is outstanding |
| cfg_round_robin | input | 1 | Round-robin replacement when full |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space ID |
| lk_vpn | input | 20 | Lookup virtual page number (VA 31:12) |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_pfn | output | PFN_W | Physical frame number on hit |
| rsp_rd | output | 1 | Read permission on hit |
| rsp_wr | output | 1 | Write permission on hit |
| rsp_ns | output | 1 | Non-secure attribute on hit |
| rf_valid | input | 1 | Install a translation |
| rf_asid | input | 7 | Refill address-space ID |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_ns | input | 1 | Refill non-secure attribute |
| fl_valid | input | 1 | Flush command strobe |
| fl_word | input | 32 | Flush command word |

## Verification
The checks assume the walker never installs a tag that is already resident, so at most one line can match any lookup; the single-hit property rests on that. The stimulus draws every tag from a fixed table of distinct keys and only refills keys known to be absent, after a full flush or after their line was evicted. Configuration inputs change only between idle cycles, never together with a refill or flush.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_NONE    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } fl_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } perm_t;
endpackage

// File: rtl/asid_tlb_line.sv
module asid_tlb_line
  import asid_tlb_pkg::*;
#(
  parameter int PFN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_active,
  input  logic              wr_en,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  perm_t             wr_perm,
  input  logic              fl_en,
  input  logic              fl_qual,
  input  logic [ASID_W-1:0] fl_asid,
  input  fl_mode_e          fl_mode,
  input  logic [17:0]       fl_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic              valid,
  output logic [PFN_W-1:0]  pfn,
  output perm_t             perm
);
  logic              valid_q, valid_d;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PFN_W-1:0]  pfn_q;
  perm_t             perm_q;
  logic              asid_ok, va_ok, kill;

  always_comb begin
    asid_ok = !fl_qual || (fl_asid == asid_q);
    unique case (fl_mode)
      FL_ALL:     va_ok = 1'b1;
      FL_SECTION: va_ok = (vpn_q[19:10] == fl_va[17:8]);
      FL_GROUP:   va_ok = (vpn_q[19:2] == fl_va);
      default:    va_ok = 1'b0;
    endcase
    kill = fl_en && valid_q && asid_ok && va_ok;
    if (wr_en)     valid_d = 1'b1;
    else if (kill) valid_d = 1'b0;
    else           valid_d = valid_q;
    hit = valid_q && line_active && !kill && (asid_q == lk_asid) && (vpn_q == lk_vpn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      asid_q <= wr_asid;
      vpn_q  <= wr_vpn;
      pfn_q  <= wr_pfn;
      perm_q <= wr_perm;
    end
  end

  assign valid = valid_q;
  assign pfn   = pfn_q;
  assign perm  = perm_q;
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     active_vec,
  input  logic [CNT_W-1:0] eff,
  input  logic             rr_en,
  input  logic             fill,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q, ptr_d, base, free_idx;
  logic             free;

  always_comb begin
    free     = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active_vec[i] && !valid_vec[i]) begin
        free     = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    base = (CNT_W'(ptr_q) >= eff) ? '0 : ptr_q;
    if (free)       victim = free_idx;
    else if (rr_en) victim = base;
    else            victim = '0;
    ptr_d = ptr_q;
    if (fill && !free && rr_en)
      ptr_d = ((CNT_W'(base) + CNT_W'(1)) >= eff) ? '0 : base + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int PFN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_active_lines,
  input  logic              cfg_hit_under_miss,
  input  logic              cfg_round_robin,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ns,
  input  logic              rf_valid,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic              rf_rd,
  input  logic              rf_wr,
  input  logic              rf_ns,
  input  logic              fl_valid,
  input  logic [31:0]       fl_word
);
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] eff;
  logic [N-1:0]     active_vec, line_hit, line_valid;
  logic [PFN_W-1:0] line_pfn [N];
  perm_t            line_perm [N];
  logic [IDX_W-1:0] victim;
  perm_t            rf_perm, sel_perm, perm_d, perm_q;
  logic [PFN_W-1:0] sel_pfn, pfn_d, pfn_q;
  logic             fire, any_hit, pend_q, pend_d, rv_d, rv_q, hit_d, hit_q;
  logic             unused_fl;

  assign unused_fl = ^fl_word[23:20];
  assign rf_perm   = '{rd: rf_rd, wr: rf_wr, ns: rf_ns};

  always_comb begin
    if (cfg_active_lines == 6'd0 || int'(cfg_active_lines) > N) eff = CNT_W'(N);
    else                                                       eff = CNT_W'(cfg_active_lines);
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign active_vec[g] = (CNT_W'(g) < eff);
    asid_tlb_line #(.PFN_W(PFN_W)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_active (active_vec[g]),
      .wr_en       (rf_valid && (victim == IDX_W'(g))),
      .wr_asid     (rf_asid),
      .wr_vpn      (rf_vpn),
      .wr_pfn      (rf_pfn),
      .wr_perm     (rf_perm),
      .fl_en       (fl_valid),
      .fl_qual     (fl_word[31]),
      .fl_asid     (fl_word[30:24]),
      .fl_mode     (fl_mode_e'(fl_word[1:0])),
      .fl_va       (fl_word[19:2]),
      .lk_asid     (lk_asid),
      .lk_vpn      (lk_vpn),
      .hit         (line_hit[g]),
      .valid       (line_valid[g]),
      .pfn         (line_pfn[g]),
      .perm        (line_perm[g])
    );
  end

  asid_tlb_victim #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (line_valid),
    .active_vec (active_vec),
    .eff        (eff),
    .rr_en      (cfg_round_robin),
    .fill       (rf_valid),
    .victim     (victim)
  );

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (line_hit[i]) begin
        sel_pfn  = sel_pfn | line_pfn[i];
        sel_perm = sel_perm | line_perm[i];
      end
    end
    any_hit  = |line_hit;
    lk_ready = !pend_q || cfg_hit_under_miss;
    fire     = lk_valid && lk_ready;
    rv_d     = fire;
    hit_d    = fire && any_hit;
    pfn_d    = hit_d ? sel_pfn : '0;
    perm_d   = hit_d ? sel_perm : '0;
    pend_d   = (pend_q && !rf_valid) || (fire && !any_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      hit_q  <= 1'b0;
      pfn_q  <= '0;
      perm_q <= '0;
      pend_q <= 1'b0;
    end else begin
      rv_q   <= rv_d;
      hit_q  <= hit_d;
      pfn_q  <= pfn_d;
      perm_q <= perm_d;
      pend_q <= pend_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = hit_q;
  assign rsp_pfn   = pfn_q;
  assign rsp_rd    = perm_q.rd;
  assign rsp_wr    = perm_q.wr;
  assign rsp_ns    = perm_q.ns;
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
  parameter int N     = 8,
  parameter int PFN_W = 20,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hit_under_miss,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_rd,
  input logic             rsp_wr,
  input logic             rsp_ns,
  input logic             rf_valid,
  input logic             fl_valid,
  input logic [31:0]      fl_word,
  input logic [N-1:0]     line_hit,
  input logic [N-1:0]     line_valid,
  input logic [IDX_W-1:0] victim,
  input logic [CNT_W-1:0] eff,
  input logic             pend_q
);
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_hit)); // R2

  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && !rsp_rd && !rsp_wr && !rsp_ns)); // R11

  AST_STALL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cfg_hit_under_miss) |-> !lk_ready); // R10

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_word == 32'h0 && !rf_valid) |=> (line_valid == '0)); // R3

  AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_word == 32'h0) |-> (line_hit == '0)); // R6

  AST_FILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> (CNT_W'(victim) < eff)); // R9

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> line_valid[$past(victim)]); // R8
endmodule

bind asid_tlb asid_tlb_checker #(.N(N), .PFN_W(PFN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .cfg_hit_under_miss (cfg_hit_under_miss),
  .lk_valid           (lk_valid),
  .lk_ready           (lk_ready),
  .rsp_valid          (rsp_valid),
  .rsp_hit            (rsp_hit),
  .rsp_pfn            (rsp_pfn),
  .rsp_rd             (rsp_rd),
  .rsp_wr             (rsp_wr),
  .rsp_ns             (rsp_ns),
  .rf_valid           (rf_valid),
  .fl_valid           (fl_valid),
  .fl_word            (fl_word),
  .line_hit           (line_hit),
  .line_valid         (line_valid),
  .victim             (victim),
  .eff                (eff),
  .pend_q             (pend_q)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  localparam int N = 8;
  localparam int PFN_W = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] cfg_active_lines;
  logic cfg_hit_under_miss, cfg_round_robin;
  logic lk_valid; logic [6:0] lk_asid; logic [19:0] lk_vpn; logic lk_ready;
  logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ns; logic [PFN_W-1:0] rsp_pfn;
  logic rf_valid; logic [6:0] rf_asid; logic [19:0] rf_vpn; logic [PFN_W-1:0] rf_pfn;
  logic rf_rd, rf_wr, rf_ns;
  logic fl_valid; logic [31:0] fl_word;

  always #2.5 clk = ~clk;

  asid_tlb #(.N(N), .PFN_W(PFN_W)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  bit         m_valid [N];
  logic [6:0] m_asid  [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_pfn  [N];
  logic [2:0] m_perm  [N];
  int         m_ptr = 0;
  bit         m_pend = 0;

  function automatic logic [31:0] va_of(int k);
    return 32'h4000_0123 + (32'(k >> 1) << 22) + (32'(k & 1) << 14);
  endfunction
  function automatic logic [6:0] asid_of(int k);
    return (k % 2 == 1) ? 7'h2A : 7'h11;
  endfunction
  function automatic logic [19:0] pfn_of(int k);
    return 20'h80000 + 20'(k * 'h111);
  endfunction
  function automatic logic [2:0] perm_of(int k);
    return 3'(k + 1);
  endfunction
  function automatic logic [31:0] fword(int mode, bit q, int k);
    logic [31:0] w = '0;
    logic [31:0] va = va_of(k);
    w[1:0] = 2'(mode);
    w[31] = q;
    w[30:24] = asid_of(k);
    if (mode == 2) w[19:10] = va[31:22];
    if (mode == 3) w[19:2] = va[31:14];
    return w;
  endfunction
  function automatic int eff_f();
    int c = int'(cfg_active_lines);
    if (c == 0 || c > N) return N;
    return c;
  endfunction
  function automatic bit fmatch(int i, logic [31:0] w);
    bit a = !w[31] || (w[30:24] == m_asid[i]);
    bit v;
    case (w[1:0])
      2'd0: v = 1;
      2'd2: v = (m_vpn[i][19:10] == w[19:10]);
      2'd3: v = (m_vpn[i][19:2] == w[19:2]);
      default: v = 0;
    endcase
    return a && v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_asid = '0; lk_vpn = '0;
    rf_valid = 0; rf_asid = '0; rf_vpn = '0; rf_pfn = '0; rf_rd = 0; rf_wr = 0; rf_ns = 0;
    fl_valid = 0; fl_word = '0;
  endtask

  // One cycle: optional lookup of key lk (bad_asid alters its ID), refill of key rk, flush word fw.
  task automatic step(bit lv, int lk, bit bad_asid, bit rv, int rk, bit fv, logic [31:0] fw, string req);
    bit rdy, fire, hit;
    int hi, eff, vic, base;
    bit free;
    logic [24:0] exp_rsp, act_rsp;
    logic [6:0] la;
    eff = eff_f();
    rdy = !m_pend || cfg_hit_under_miss;
    check(lk_ready == rdy, "R10", 64'(lk_ready), 64'(rdy));
    la = bad_asid ? 7'h55 : asid_of(lk);
    hit = 0; hi = 0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && i < eff && !(fv && fmatch(i, fw)) &&
          m_asid[i] == la && m_vpn[i] == va_of(lk)[31:12]) begin
        hit = 1; hi = i;
      end
    fire = lv && rdy;
    exp_rsp = {fire, fire && hit, (fire && hit) ? m_pfn[hi] : 20'h0, (fire && hit) ? m_perm[hi] : 3'h0};
    free = 0; vic = 0;
    for (int i = N - 1; i >= 0; i--)
      if (i < eff && !m_valid[i]) begin free = 1; vic = i; end
    base = (m_ptr >= eff) ? 0 : m_ptr;
    if (!free) vic = cfg_round_robin ? base : 0;
    lk_valid = lv; lk_asid = la; lk_vpn = va_of(lk)[31:12];
    rf_valid = rv; rf_asid = asid_of(rk); rf_vpn = va_of(rk)[31:12]; rf_pfn = pfn_of(rk);
    {rf_rd, rf_wr, rf_ns} = perm_of(rk);
    fl_valid = fv; fl_word = fw;
    @(posedge clk);
    if (fv) for (int i = 0; i < N; i++) if (m_valid[i] && fmatch(i, fw)) m_valid[i] = 0;
    if (rv) begin
      m_valid[vic] = 1; m_asid[vic] = asid_of(rk); m_vpn[vic] = va_of(rk)[31:12];
      m_pfn[vic] = pfn_of(rk); m_perm[vic] = perm_of(rk);
      if (!free && cfg_round_robin) m_ptr = (base + 1 >= eff) ? 0 : base + 1;
    end
    m_pend = (m_pend && !rv) || (fire && !hit);
    @(negedge clk);
    idle_inputs();
    act_rsp = {rsp_valid, rsp_hit, rsp_pfn, rsp_rd, rsp_wr, rsp_ns};
    check(act_rsp == exp_rsp, req, 64'(act_rsp), 64'(exp_rsp));
  endtask

  task automatic look(int k, string req);  step(1, k, 0, 0, 0, 0, 0, req); endtask
  task automatic fill(int k, string req);  step(0, 0, 0, 1, k, 0, 0, req); endtask
  task automatic flush_all();             step(0, 0, 0, 0, 0, 1, 32'h0, "R3"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    string rq;
    rst_n = 0;
    cfg_active_lines = 6'd0; cfg_hit_under_miss = 1; cfg_round_robin = 1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(lk_ready == 1'b1, "R1", 64'(lk_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
    look(3, "R1");
    m_pend = 0; fill(3, "R1"); flush_all();

    // R2 basic fill and hit, wrong ID miss, R11 miss payload
    for (int k = 0; k < N; k++) fill(k, "R8");
    for (int k = 0; k < N; k++) look(k, "R2");
    step(1, 2, 1, 0, 0, 0, 0, "R11");
    look(12, "R11");
    fill(12, "R8");

    // R7 same-cycle lookup and refill
    flush_all();
    step(1, 5, 0, 1, 5, 0, 0, "R7");
    look(5, "R7");

    // Flush sweep over mode, qualifier, target key
    for (int mode = 0; mode < 4; mode++)
      for (int q = 0; q < 2; q++)
        for (int t = 0; t < N; t++) begin
          rq = (q == 1) ? "R4" : ((mode >= 2) ? "R5" : "R3");
          flush_all();
          for (int k = 0; k < N; k++) fill(k, "R8");
          step(1, t, 0, 0, 0, 1, fword(mode, bit'(q), t), "R6");
          for (int k = 0; k < N; k++) look(k, rq);
        end

    // R8 round-robin replacement, then fixed line 0
    flush_all();
    for (int k = 0; k < N; k++) fill(k, "R8");
    for (int k = 8; k < 11; k++) fill(k, "R8");
    for (int k = 0; k < 11; k++) look(k, "R8");
    cfg_round_robin = 0;
    fill(11, "R8"); fill(12, "R8");
    for (int k = 0; k < 13; k++) look(k, "R8");
    cfg_round_robin = 1;

    // R9 active line count
    flush_all();
    cfg_active_lines = 6'd3;
    for (int k = 0; k < 5; k++) fill(k, "R9");
    for (int k = 0; k < 5; k++) look(k, "R9");
    cfg_active_lines = 6'd40;
    for (int k = 5; k < 10; k++) fill(k, "R9");
    for (int k = 0; k < 10; k++) look(k, "R9");
    cfg_active_lines = 6'd0;

    // R10 blocking and hit-under-miss
    flush_all();
    fill(0, "R10");
    cfg_hit_under_miss = 0;
    look(1, "R10");
    look(0, "R10");
    look(0, "R10");
    fill(1, "R10");
    look(1, "R10");
    cfg_hit_under_miss = 1;
    look(2, "R10");
    look(0, "R10");
    fill(2, "R10");
    look(2, "R10");

    finish_run();
  end
endmodule